// File: doc/BRIEF.md
# Latched-Address 3-to-8 Decoder

This block turns a 3-bit address into eight active-low select lines. At most one line is low at any time. A hold register sits in front of the decode logic. While the latch-enable input is low, the hold is open and the outputs follow the live address in the same cycle. When latch-enable goes high, the block keeps decoding the address it captured last and ignores the address pins.

Two output enables of opposite polarity gate the result. The outputs are active only when the low-true enable is low and the high-true enable is high. In every other combination all eight lines stay high. The captured address survives while the outputs are gated off.

The storage is a clocked register, not a level-sensitive latch. It loads the address on every rising clock edge while latch-enable is low, and it holds its value while latch-enable is high. Because of this, an address is captured only if it was present at a clock edge before latch-enable rose. A synchronous active-low reset clears the stored address to zero.

Top module: `ladec_latched_decoder`

## Requirements
- R1: When the outputs are enabled, exactly one output is low. Output n is the one selected when the effective address equals n in binary, with addr[0] as the least significant bit.
- R2: While le is 0, the effective address is the live addr input, and the outputs reflect a change of addr in the same cycle.
- R3: When le changes from 0 to 1, the effective address becomes the addr value sampled at the last rising clock edge at which le was still 0.
- R4: While le stays 1, changes on addr do not change the outputs.
- R5: All eight outputs are 1 unless en_n is 0 and en is 1 at the same time.
- R6: The stored address is kept while the outputs are disabled. Enabling again with le still 1 selects the same output as before.
- R7: Two outputs are never low together.
- R8: A synchronous reset (rst_n low at a rising clock edge) clears the stored address to 0. After reset with le held at 1, enabling the outputs drives y_n[0] low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address hold register |
| rst_n | input | 1 | Synchronous active-low reset, clears the stored address |
| addr | input | 3 | Address to decode, bit 0 least significant |
| le | input | 1 | Latch enable: 0 = open (follow addr), 1 = hold |
| en_n | input | 1 | Output enable, active low |
| en | input | 1 | Output enable, active high |
| y_n | output | 8 | Decoded select lines, active low |

## Verification
The assertions assume that the inputs change only away from the rising clock edge. They also assume that an address meant for capture is stable across at least one rising edge while le is low, before le rises. The capture property compares against the address seen at the previous edge, so it relies on that setup. The stimulus changes every input shortly after the falling clock edge, and it always lets one full clock edge pass with le low before raising le. The stability property covers only cycles in which both the hold state and the enable state are unchanged, so enable sweeps made while le is high stay inside it.

// File: rtl/ladec_pkg.sv
// Package: shared sizing and the decode helper for the latched decoder.
// Assumes: address widths stay small (the output count is 2**width).
package ladec_pkg;

    localparam int unsigned LADEC_ADDR_W = 3;

    // Purpose: one-hot vector of width 2**LADEC_ADDR_W for a given index.
    function automatic logic [(1 << LADEC_ADDR_W)-1:0] ladec_hot(input logic [LADEC_ADDR_W-1:0] idx);
        logic [(1 << LADEC_ADDR_W)-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ladec_addr_hold.sv
// Module: address hold stage.
// Loads the address on each rising clock edge while le is low and freezes it
// while le is high. The effective address is the live input while le is low
// and the stored value otherwise.
// Assumes: synchronous active-low reset; addr is settled at the clock edge.
module ladec_addr_hold #(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              le,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] held_q;

    // Purpose: track the address while open, keep it while closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (!le) begin
            held_q <= addr;
        end
    end

    // Purpose: select live or stored address.
    always_comb begin
        eff_addr = le ? held_q : addr;
    end

endmodule

// File: rtl/ladec_onehot.sv
// Module: binary to one-hot decoder (active high).
// Assumes: OUT_N == 2**ADDR_W.
module ladec_onehot #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned OUT_N  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [OUT_N-1:0]  hot
);

    // Purpose: one comparator per output line.
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign hot[g] = (sel == ADDR_W'(g));
    end

endmodule

// File: rtl/ladec_out_gate.sv
// Module: output enable gate.
// Inverts the one-hot select to active-low lines when en_n=0 and en=1, and
// otherwise holds all lines high.
// Assumes: hot carries at most one set bit.
module ladec_out_gate #(
    parameter int unsigned OUT_N = 8
) (
    input  logic [OUT_N-1:0] hot,
    input  logic             en_n,
    input  logic             en,
    output logic [OUT_N-1:0] y_n
);

    logic active;

    // Purpose: combine the two enables and drive the active-low lines.
    always_comb begin
        active = (!en_n) && en;
        y_n    = active ? ~hot : '1;
    end

endmodule

// File: rtl/ladec_latched_decoder.sv
// Module: top level of the latched-address 3-to-8 decoder.
// Chain: address hold -> one-hot decode -> enable gate.
// Assumes: inputs change away from the rising clock edge.
module ladec_latched_decoder #(
    parameter int unsigned ADDR_W = ladec_pkg::LADEC_ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     le,
    input  logic                     en_n,
    input  logic                     en,
    output logic [(1 << ADDR_W)-1:0] y_n
);

    localparam int unsigned OUT_N = 1 << ADDR_W;

    logic [ADDR_W-1:0] eff_addr;
    logic [OUT_N-1:0]  hot;

    ladec_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .le       (le),
        .eff_addr (eff_addr)
    );

    ladec_onehot #(.ADDR_W(ADDR_W), .OUT_N(OUT_N)) u_dec (
        .sel (eff_addr),
        .hot (hot)
    );

    ladec_out_gate #(.OUT_N(OUT_N)) u_gate (
        .hot  (hot),
        .en_n (en_n),
        .en   (en),
        .y_n  (y_n)
    );

endmodule

// File: rtl/ladec_latched_decoder_chk.sv
// Module: assertion checker for the latched decoder, attached with bind.
// Assumes: inputs change away from the rising clock edge, and a captured
// address is present at one edge with le low before le rises.
module ladec_latched_decoder_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        addr,
    input logic                     le,
    input logic                     en_n,
    input logic                     en,
    input logic [(1 << ADDR_W)-1:0] y_n
);

    logic on;
    assign on = (!en_n) && en;

    AST_ONE_LOW_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> ($countones(~y_n) == 1));                                         // R1

    AST_OPEN_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !le) |-> (y_n[addr] == 1'b0));                                    // R2

    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(le) && on) |-> (y_n[$past(addr)] == 1'b0));      // R3

    AST_HOLD_WHILE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && le && $past(le) && on && $past(on)) |-> $stable(y_n)); // R4

    AST_OFF_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> (&y_n));                                                         // R5

    AST_NEVER_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~y_n) <= 1);                                                  // R7

endmodule

bind ladec_latched_decoder ladec_latched_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .le    (le),
    .en_n  (en_n),
    .en    (en),
    .y_n   (y_n)
);

// File: tb/ladec_latched_decoder_tb.sv
// Directed bench for the latched decoder: one task per scenario.
module ladec_latched_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       le = 1'b0;
    logic       en_n = 1'b1;
    logic       en = 1'b0;
    logic [7:0] y_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    ladec_latched_decoder u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .le    (le),
        .en_n  (en_n),
        .en    (en),
        .y_n   (y_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] sel_low(input int idx);
        return ~(8'b1 << idx);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: y_n=%b expected=%b", req, act, exp);
        end
    endtask

    // Wait to the falling edge, then drive, then let logic settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; le = 1'b1; en_n = 1'b1; en = 1'b0; addr = 3'd6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5 reset disabled", y_n, 8'hFF);
        en_n = 1'b0; en = 1'b1;
        #2;
        chk("R8 reset clears stored addr", y_n, sel_low(0));
        en_n = 1'b1; en = 1'b0;
    endtask

    task automatic t_sweep();
        step();
        le = 1'b0; en_n = 1'b0; en = 1'b1;
        for (int a = 0; a < 8; a++) begin
            addr = a[2:0];
            #2;
            chk("R1 R2 R7 transparent sweep", y_n, sel_low(a));
        end
        // Change between clock edges: output follows at once (R2).
        step();
        addr = 3'd3;
        #2;
        chk("R2 same-cycle follow", y_n, sel_low(3));
    endtask

    task automatic t_latch();
        step();
        le = 1'b0; addr = 3'd5;
        step();            // one edge passes with le low and addr=5
        le = 1'b1; addr = 3'd2;
        #2;
        chk("R3 capture on le rise", y_n, sel_low(5));
        for (int a = 0; a < 8; a++) begin
            step();
            addr = a[2:0];
            #2;
            chk("R4 closed ignores addr", y_n, sel_low(5));
        end
        step();
        le = 1'b0;
        #2;
        chk("R2 reopen follows live addr", y_n, sel_low(7));
    endtask

    task automatic t_enables();
        int n_active;
        step();
        le = 1'b0; addr = 3'd6;
        step();
        le = 1'b1; addr = 3'd1;
        n_active = 0;
        for (int c = 0; c < 4; c++) begin
            step();
            en_n = c[0]; en = c[1];
            addr = 3'(c + 2);
            #2;
            if (y_n != 8'hFF) n_active++;
            if (c == 2) chk("R1 R6 enabled keeps stored addr", y_n, sel_low(6));
            else        chk("R5 gated off all high", y_n, 8'hFF);
        end
        chk("R5 only one enable combination active", 8'(n_active), 8'd1);
        step();
        en_n = 1'b0; en = 1'b1;
        #2;
        chk("R6 stored addr survives disable", y_n, sel_low(6));
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_latch();
        t_enables();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule